// File: doc/BRIEF.md
# Serial Port FIFO Status and Interrupt Flags

This block holds the data FIFOs and the status logic of a frame-based serial port. A CPU-side write port pushes words into a transmit FIFO and programs a control word. A serial shifter, which sits outside this block, pulls words from the transmit FIFO and pushes received words into a receive FIFO. The CPU drains the receive FIFO through a show-ahead read port.

The block watches four conditions. The receive data request is a live level that compares the receive FIFO occupancy with a programmable watermark. The other three are sticky error flags. Transmit overrun sets when the CPU writes to a full transmit FIFO. Transmit underrun sets when the shifter asks for a word while the transmit FIFO is empty; the shifter then gets the last word it was sent once more. Frame sync error sets when a frame sync pulse arrives before the current frame has finished its enabled slot transfers. Each error flag clears when a one is written to its bit. Per-bit enables combine the flags into one transmit interrupt and one receive interrupt.

Top module: `sfifo_stat`

## Requirements
- R1: After reset, all status bits, both FIFO counts, both interrupts and `tx_word` are 0.
- R2: Status bit 3 (receive data request) equals 1 exactly while `rx_count` is greater than the watermark held in control bits [3:0]. It is a live level and is not sticky.
- R3: `rx_irq` equals status bit 3 ANDed with control bit 15.
- R4: Words written at address 0 leave the transmit FIFO in the order they were written. Each one appears on `tx_word` in the cycle after the `tx_load` that takes it.
- R5: A write at address 0 while `tx_count` is 16 sets status bit 1 (overrun). The word is discarded and the count stays at 16.
- R6: A `tx_load` while the transmit FIFO is empty sets status bit 0 (underrun) and leaves `tx_word` at the last word sent. Before any word has been sent, that value is 0.
- R7: The frame sync error (status bit 2) is evaluated only while control bit 4 (transmit enable) or control bit 5 (receive enable) is 1. The first `fs_pulse` after enabling only opens a frame. A later `fs_pulse` sets status bit 2 when fewer `xfer_done` pulses than control bits [9:8] have arrived since the previous `fs_pulse`. An `xfer_done` in the same cycle as the `fs_pulse` counts toward the closing frame.
- R8: While both enables are 0, `fs_pulse` never sets status bit 2.
- R9: A write at address 1 clears each of status bits [2:0] whose data bit is 1. A data bit of 0 leaves that flag unchanged.
- R10: If a set event and a clear write hit the same flag in the same cycle, the flag ends up 1.
- R11: `tx_irq` is the OR of status bits [2:0], each ANDed with control bits [14:12] in the same bit order.
- R12: The receive FIFO returns words in push order on `rd_data`, and `rd_pop` removes the head. An `rx_push` while `rx_count` is 16 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 2 | Write target: 0 transmit data, 1 status clear, 2 control |
| wr_data | input | 32 | CPU write data |
| tx_load | input | 1 | Shifter request for the next transmit word |
| tx_word | output | 32 | Word handed to the shifter |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_word | input | 32 | Received word |
| rd_pop | input | 1 | CPU removes the head of the receive FIFO |
| rd_data | output | 32 | Head of the receive FIFO |
| fs_pulse | input | 1 | Frame sync pulse |
| xfer_done | input | 1 | One enabled slot transfer completed |
| tx_count | output | 5 | Transmit FIFO occupancy |
| rx_count | output | 5 | Receive FIFO occupancy |
| status | output | 4 | {rdreq, fs error, overrun, underrun} |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The hardest state to reach is a flag that is being set and cleared in the same cycle. An underrun has to be forced by a `tx_load` on an empty FIFO while the clear write for that bit is on the write port, so the bench drives both strobes inside one cycle. A frame sync error also needs a frame that has already been opened and then left short by exactly one transfer. The bench gets there by enabling the port, sending an opening pulse, counting out the transfers and closing both a full frame and a short one. The watermark comparison is swept over every watermark value against every occupancy from empty to full, and that sweep also pushes the receive FIFO past full.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    localparam int WM_W   = 4;
    localparam int SLOT_W = 2;
    localparam int NFLAG  = 3;

    localparam logic [1:0] A_TXD = 2'd0;
    localparam logic [1:0] A_CLR = 2'd1;
    localparam logic [1:0] A_CTL = 2'd2;

    // status bit order: 0 underrun, 1 overrun, 2 frame sync error, 3 rdreq
    typedef struct packed {
        logic [3:0]        ie;
        logic [SLOT_W-1:0] slots;
        logic              rx_en;
        logic              tx_en;
        logic [WM_W-1:0]   wm;
    } ctl_t;
endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_q, st_d;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign head  = mem_q[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + CW'(1);
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wp] <= din;
    end
endmodule

// File: rtl/sfs_frame_mon.sv
module sfs_frame_mon #(
    parameter int SLOT_W = 2,
    localparam int CW    = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              fs,
    input  logic              xfer_done,
    input  logic [SLOT_W-1:0] slots,
    output logic              err
);
    typedef struct packed {
        logic          open;
        logic [CW-1:0] done;
    } st_t;

    st_t st_q, st_d;
    logic [CW-1:0] done_now;

    always_comb begin
        st_d     = st_q;
        done_now = st_q.done;
        if (xfer_done && st_q.done != '1) done_now = st_q.done + CW'(1);
        err = 1'b0;
        if (!arm) begin
            st_d = '0;
        end else if (fs) begin
            err       = st_q.open && (done_now < CW'(slots));
            st_d.open = 1'b1;
            st_d.done = '0;
        end else begin
            st_d.done = done_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sfifo_stat.sv
module sfifo_stat
    import sfs_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          tx_load,
    output logic [DW-1:0] tx_word,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_word,
    input  logic          rd_pop,
    output logic [DW-1:0] rd_data,
    input  logic          fs_pulse,
    input  logic          xfer_done,
    output logic [CW-1:0] tx_count,
    output logic [CW-1:0] rx_count,
    output logic [3:0]    status,
    output logic          tx_irq,
    output logic          rx_irq
);
    typedef struct packed {
        ctl_t            ctl;
        logic [NFLAG-1:0] err;
        logic [DW-1:0]   last;
    } st_t;

    st_t st_q, st_d;

    logic [DW-1:0] tx_head;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          fs_err;
    logic          txd_wr, clr_wr, ctl_wr;
    logic [NFLAG-1:0] set_ev, clr_ev;
    logic          rdreq;

    assign txd_wr = wr_en && (wr_addr == A_TXD);
    assign clr_wr = wr_en && (wr_addr == A_CLR);
    assign ctl_wr = wr_en && (wr_addr == A_CTL);

    sfs_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(txd_wr), .din(wr_data), .pop(tx_load),
        .head(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    sfs_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(rx_word), .pop(rd_pop),
        .head(rd_data), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    sfs_frame_mon #(.SLOT_W(SLOT_W)) u_fmon (
        .clk(clk), .rst_n(rst_n),
        .arm(st_q.ctl.tx_en || st_q.ctl.rx_en),
        .fs(fs_pulse), .xfer_done(xfer_done),
        .slots(st_q.ctl.slots), .err(fs_err)
    );

    always_comb begin
        st_d      = st_q;
        set_ev[0] = tx_load && tx_empty;
        set_ev[1] = txd_wr && tx_full;
        set_ev[2] = fs_err;
        clr_ev    = clr_wr ? wr_data[NFLAG-1:0] : '0;
        for (int i = 0; i < NFLAG; i++) begin
            st_d.err[i] = set_ev[i] || (st_q.err[i] && !clr_ev[i]);
        end
        if (ctl_wr) begin
            st_d.ctl.wm    = wr_data[WM_W-1:0];
            st_d.ctl.tx_en = wr_data[4];
            st_d.ctl.rx_en = wr_data[5];
            st_d.ctl.slots = wr_data[8 +: SLOT_W];
            st_d.ctl.ie    = wr_data[15:12];
        end
        if (tx_load && !tx_empty) st_d.last = tx_head;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdreq   = rx_count > CW'(st_q.ctl.wm);
    assign status  = {rdreq, st_q.err};
    assign tx_word = st_q.last;
    assign tx_irq  = |(st_q.err & st_q.ctl.ie[NFLAG-1:0]);
    assign rx_irq  = rdreq && st_q.ctl.ie[3];
endmodule

// File: rtl/sfifo_stat_chk.sv
module sfifo_stat_chk #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          tx_load,
    input logic [DW-1:0] tx_word,
    input logic [CW-1:0] tx_count,
    input logic [CW-1:0] rx_count,
    input logic [3:0]    status,
    input logic          tx_irq,
    input logic          rx_irq,
    input logic [3:0]    wm,
    input logic [3:0]    ie
);
    AST_RDREQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] == (rx_count > CW'(wm))); // R2
    AST_RX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == (status[3] && ie[3])); // R3
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && tx_count == CW'(DEPTH)) |=> status[1]); // R5
    AST_OVR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0 && tx_count == CW'(DEPTH) && !tx_load)
        |=> tx_count == CW'(DEPTH)); // R5
    AST_UDR_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && tx_count == '0) |=> (status[0] && $stable(tx_word))); // R6
    AST_W1C_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && wr_data[1]) |=> !status[1]); // R9
    AST_TX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq == |(status[2:0] & ie[2:0])); // R11
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH))); // R12
endmodule

bind sfifo_stat sfifo_stat_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_load(tx_load), .tx_word(tx_word), .tx_count(tx_count), .rx_count(rx_count),
    .status(status), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .wm(st_q.ctl.wm), .ie(st_q.ctl.ie)
);

// File: tb/sfifo_stat_test.sv
module sfifo_stat_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tx_load = 1'b0;
    logic [31:0] tx_word;
    logic        rx_push = 1'b0;
    logic [31:0] rx_word = '0;
    logic        rd_pop = 1'b0;
    logic [31:0] rd_data;
    logic        fs_pulse = 1'b0;
    logic        xfer_done = 1'b0;
    logic [4:0]  tx_count, rx_count;
    logic [3:0]  status;
    logic        tx_irq, rx_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sfifo_stat uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tx_load(tx_load), .tx_word(tx_word), .rx_push(rx_push), .rx_word(rx_word),
        .rd_pop(rd_pop), .rd_data(rd_data), .fs_pulse(fs_pulse), .xfer_done(xfer_done),
        .tx_count(tx_count), .rx_count(rx_count), .status(status),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(int wm, bit txe, bit rxe, int slots, int ie);
        return 32'(wm & 15) | (32'(txe) << 4) | (32'(rxe) << 5)
             | (32'(slots & 3) << 8) | (32'(ie & 15) << 12);
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic load();
        tx_load = 1'b1; step(); tx_load = 1'b0;
    endtask

    task automatic fs();
        fs_pulse = 1'b1; step(); fs_pulse = 1'b0;
    endtask

    task automatic xd();
        xfer_done = 1'b1; step(); xfer_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 status", 32'(status), 0);
        check("R1 tx_count", 32'(tx_count), 0);
        check("R1 rx_count", 32'(rx_count), 0);
        check("R1 irqs", {30'd0, tx_irq, rx_irq}, 0);
        check("R1 tx_word", tx_word, 0);

        // R6 underrun before anything was sent gives zeros
        load();
        check("R6 first underrun flag", 32'(status[0]), 1);
        check("R6 first underrun word", tx_word, 0);
        // R9 write of zero leaves the flag
        wr(2'd1, 32'h0);
        check("R9 zero write keeps flag", 32'(status[0]), 1);
        // R11 enable underrun interrupt
        wr(2'd2, ctl(15, 0, 0, 0, 4'b0001));
        check("R11 tx_irq on underrun", 32'(tx_irq), 1);
        wr(2'd1, 32'h1);
        check("R9 clear underrun", 32'(status[0]), 0);
        check("R11 tx_irq drops", 32'(tx_irq), 0);

        // R4/R5 fill, overflow, drain
        for (int k = 0; k < 16; k++) wr(2'd0, 32'h500 + 32'(k));
        check("R5 full count", 32'(tx_count), 16);
        check("R5 no overrun yet", 32'(status[1]), 0);
        wr(2'd0, 32'hDEAD);
        check("R5 overrun flag", 32'(status[1]), 1);
        check("R5 count held", 32'(tx_count), 16);
        for (int k = 0; k < 16; k++) begin
            load();
            check("R4 order", tx_word, 32'h500 + 32'(k));
        end
        check("R4 empty after drain", 32'(tx_count), 0);
        load();
        check("R6 underrun flag", 32'(status[0]), 1);
        check("R6 repeat last", tx_word, 32'h50F);
        wr(2'd1, 32'h2);
        check("R9 clear only overrun", 32'(status[1:0]), 32'b01);

        // R10 set and clear in the same cycle
        wr(2'd1, 32'h1);
        check("R9 underrun cleared", 32'(status[0]), 0);
        tx_load = 1'b1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h1;
        step();
        tx_load = 1'b0; wr_en = 1'b0;
        check("R10 set wins over clear", 32'(status[0]), 1);
        wr(2'd1, 32'h7);
        check("R9 clear all", 32'(status[2:0]), 0);

        // R7 frame sync error with two slots
        wr(2'd2, ctl(15, 1, 0, 2, 4'b0100));
        fs();
        check("R7 first pulse opens frame", 32'(status[2]), 0);
        xd(); xd(); fs();
        check("R7 full frame no error", 32'(status[2]), 0);
        xd(); fs();
        check("R7 short frame error", 32'(status[2]), 1);
        check("R11 tx_irq on fs error", 32'(tx_irq), 1);
        wr(2'd1, 32'h4);
        // same-cycle xfer_done counts toward the closing frame
        xd(); xfer_done = 1'b1; fs_pulse = 1'b1; step(); xfer_done = 1'b0; fs_pulse = 1'b0;
        check("R7 same-cycle done counts", 32'(status[2]), 0);
        // receive enable alone also arms
        wr(2'd2, ctl(15, 0, 1, 2, 0));
        fs(); fs();
        check("R7 rx enable arms", 32'(status[2]), 1);
        wr(2'd1, 32'h4);
        // R8 disabled: no evaluation
        wr(2'd2, ctl(15, 0, 0, 3, 0));
        fs(); fs(); fs();
        check("R8 disabled no error", 32'(status[2]), 0);

        // R2/R3/R12 watermark sweep over all values and occupancies
        for (int wm = 0; wm < 16; wm++) begin
            wr(2'd2, ctl(wm, 0, 0, 0, (wm % 2 == 0) ? 4'b1000 : 4'b0000));
            for (int n = 0; n <= 16; n++) begin
                check("R2 rdreq level", 32'(status[3]), (n > wm) ? 1 : 0);
                check("R3 rx_irq", 32'(rx_irq), (wm % 2 == 0 && n > wm) ? 1 : 0);
                if (n < 16) begin
                    rx_push = 1'b1; rx_word = 32'(wm * 256 + n);
                    step(); rx_push = 1'b0;
                end
            end
            rx_push = 1'b1; rx_word = 32'hBAD; step(); rx_push = 1'b0;
            check("R12 full push dropped", 32'(rx_count), 16);
            for (int n = 0; n < 16; n++) begin
                check("R12 read order", rd_data, 32'(wm * 256 + n));
                rd_pop = 1'b1; step(); rd_pop = 1'b0;
                check("R2 rdreq follows drain", 32'(status[3]), (15 - n > wm) ? 1 : 0);
            end
            check("R12 drained", 32'(rx_count), 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule